// File: doc/BRIEF.md
# Write-Back Data Cache with Half-Line Dirty Tracking

This block is a set-associative data cache placed between a processor data port and a word-wide memory bus. A request carries an operation, an access size, a byte address, write data and a way number. Reads that hit return the cached word in one cycle. Writes that hit merge into the cached word and mark only the affected half of the line as dirty, so no bus write is issued. Writes that miss go out to the bus as a single word transfer with byte enables, and no line is allocated.

A read miss replaces the line in the way named by the request. The cache first writes back any dirty halves of that line, then refills all eight words from the bus. Three clean operations flush dirty halves without evicting anything: by set and way, by address, and across the whole cache. Each half-line flush is its own four-word burst. Every response carries the access cost in processor cycles, computed from a non-sequential access cost, a sequential access cost and a clock ratio shift.

Top module: `wb_dcache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and mem_valid are 0, and every line is invalid, so the first read of any address misses (rsp_hit 0).
- R2: A read hit returns the current word value in rsp_rdata with rsp_hit 1, rsp_cost 1 and no bus transfer.
- R3: A write hit of any size (req_size 0 byte, 1 halfword, 2 word) merges little-endian into the cached word and reports rsp_absorbed 1, rsp_hit 1 and rsp_cost 1, with no bus transfer. Byte lane = addr[1:0], halfword lane = addr[1]. The data to write sits in the low bits of req_wdata.
- R4: A write hit marks as dirty only the half of the line chosen by address bit 4 (1 upper, 0 lower). A later flush writes back only that half.
- R5: A write miss issues exactly one bus write with the merged byte enables on mem_be and the lanes replicated on mem_wdata. It reports rsp_absorbed 0 and cost NSEQ_COST<<CLK_SHIFT, and allocates no line, so a following read of that line misses.
- R6: A read miss uses way req_way as the victim. It writes back the victim's dirty halves first, lower half before upper, each in ascending word order, and then reads the eight words of the new line in ascending order. The response carries the requested word.
- R7: A read miss costs one line refill ((NSEQ_COST + 7*SEQ_COST)<<CLK_SHIFT) plus one half write-back ((NSEQ_COST + 3*SEQ_COST)<<CLK_SHIFT) for each dirty half of the victim.
- R8: Clean by set and way (op 2; set from addr[6:5], way from req_way) does nothing at cost 0 on an invalid line. On a valid line it writes back the dirty halves and clears both dirty flags, and the line stays valid.
- R9: Clean by address (op 3) cleans the way holding that address and reports rsp_hit 1. On a miss it reports rsp_hit 0 and cost 0, with no bus transfer.
- R10: Clean all (op 4) flushes every dirty half of every line, with a cost equal to the sum of the half write-back costs. Afterwards the memory holds the value last written to every address.
- R11: While mem_valid is 1 and mem_ready is 0, mem_addr, mem_we and mem_wdata hold steady. Each accepted transfer moves one word.
- R12: One request is handled at a time: req_ready is 1 only when idle, mem_valid is never 1 while idle, and rsp_valid is a one-cycle pulse followed by req_ready 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when req_ready is 1 |
| req_ready | output | 1 | Cache idle and able to take a request |
| req_op | input | 3 | 0 read, 1 write, 2 clean set/way, 3 clean by address, 4 clean all |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word (writes) |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| req_way | input | WAY_W | Victim way for read miss, way for clean set/way |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Read word |
| rsp_hit | output | 1 | Lookup hit (read, write, clean by address) |
| rsp_absorbed | output | 1 | Write held in cache; no bus write |
| rsp_cost | output | COST_W | Access cost in processor cycles |
| mem_valid | output | 1 | Bus transfer requested |
| mem_ready | input | 1 | Bus accepts the transfer this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_be | output | 4 | Byte enables |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |

## Verification
A request is taken on the edge after it is driven. A lookup state follows, so a hit raises rsp_valid two edges after acceptance. Misses and cleans add one cycle per accepted bus word, plus one cycle for each clean half that is skipped. Bus ready is random, so the bench never counts cycles for those. It drives at falling edges and polls rsp_valid at falling edges. It counts the bus transfers seen between acceptance and the response, and compares them with the counts its own cache model expects. Each bus write is checked against the model memory at the falling edge where the transfer completes.

// File: rtl/wb_dcache.sv
module wb_dcache #(
  parameter int WAYS       = 4,
  parameter int LINES      = 4,
  parameter int LINE_WORDS = 8,
  parameter int NSEQ_COST  = 5,
  parameter int SEQ_COST   = 2,
  parameter int CLK_SHIFT  = 1,
  parameter int COST_W     = 16,
  parameter int WAY_W      = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [WAY_W-1:0]  req_way,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_hit,
  output logic              rsp_absorbed,
  output logic [COST_W-1:0] rsp_cost,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int WRD_W  = $clog2(LINE_WORDS);
  localparam int HWRD_W = WRD_W - 1;
  localparam int OFF_W  = WRD_W + 2;
  localparam int TAG_W  = 32 - OFF_W - IDX_W;
  localparam int ENT    = WAYS * LINES;
  localparam int E_W    = WAY_W + IDX_W;
  localparam logic [COST_W-1:0] HALF_COST =
    COST_W'((NSEQ_COST + SEQ_COST * (LINE_WORDS / 2 - 1)) << CLK_SHIFT);
  localparam logic [COST_W-1:0] LINE_COST =
    COST_W'((NSEQ_COST + SEQ_COST * (LINE_WORDS - 1)) << CLK_SHIFT);
  localparam logic [COST_W-1:0] THRU_COST = COST_W'(NSEQ_COST << CLK_SHIFT);

  localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_CSW = 3'd2,
                         OP_CAD = 3'd3, OP_CALL = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_WB, S_FILL, S_THRU, S_RESP} st_t;
  st_t st;

  logic [2:0]        op_q;
  logic [1:0]        size_q;
  logic [31:0]       addr_q, wdata_q, rdata_q;
  logic [WAY_W-1:0]  way_q, tgt_way;
  logic [IDX_W-1:0]  tgt_idx;
  logic              half_q, hit_q, abs_q;
  logic [WRD_W-1:0]  word_q;
  logic [COST_W-1:0] cost_q;

  logic [31:0]      dmem [ENT*LINE_WORDS];
  logic [TAG_W-1:0] tagm [ENT];
  logic [ENT-1:0]   vld, dlo, dhi;

  wire [TAG_W-1:0] a_tag  = addr_q[31 -: TAG_W];
  wire [IDX_W-1:0] a_idx  = addr_q[OFF_W +: IDX_W];
  wire [WRD_W-1:0] a_wrd  = addr_q[2 +: WRD_W];
  wire             a_half = addr_q[OFF_W-1];

  logic [WAYS-1:0]  hitv;
  logic [WAY_W-1:0] hway;
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    wire [E_W-1:0] e = {WAY_W'(w), a_idx};
    assign hitv[w] = vld[e] && (tagm[e] == a_tag);
  end
  always_comb begin
    hway = '0;
    for (int w = 0; w < WAYS; w++) if (hitv[w]) hway = WAY_W'(w);
  end
  wire hit = |hitv;
  wire [E_W-1:0] hit_e = {hway, a_idx};
  wire [E_W-1:0] tgt_e = {tgt_way, tgt_idx};

  logic [3:0]  be;
  logic [31:0] lane;
  always_comb begin
    case (size_q)
      2'd0:    begin be = 4'b0001 << addr_q[1:0]; lane = {4{wdata_q[7:0]}}; end
      2'd1:    begin be = addr_q[1] ? 4'b1100 : 4'b0011; lane = {2{wdata_q[15:0]}}; end
      default: begin be = 4'b1111; lane = wdata_q; end
    endcase
  end
  wire [31:0] bmask  = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  wire [31:0] hword  = dmem[{hit_e, a_wrd}];
  wire [31:0] merged = (hword & ~bmask) | (lane & bmask);

  wire tdirty   = half_q ? dhi[tgt_e] : dlo[tgt_e];
  wire wb_need  = vld[tgt_e] && tdirty;
  wire wb_last  = &word_q[HWRD_W-1:0];
  wire half_end = (st == S_WB) && (!wb_need || (mem_ready && wb_last));
  wire wr_hit   = (st == S_LOOK) && (op_q == OP_WR) && hit;
  wire fill_we  = (st == S_FILL) && mem_ready;
  wire fill_end = fill_we && (&word_q);

  assign req_ready    = (st == S_IDLE);
  assign rsp_valid    = (st == S_RESP);
  assign rsp_rdata    = rdata_q;
  assign rsp_hit      = hit_q;
  assign rsp_absorbed = abs_q;
  assign rsp_cost     = cost_q;

  assign mem_valid = ((st == S_WB) && wb_need) || (st == S_FILL) || (st == S_THRU);
  assign mem_we    = (st == S_WB) || (st == S_THRU);
  assign mem_be    = (st == S_THRU) ? be : 4'hF;
  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_WB: begin
        mem_addr  = {tagm[tgt_e], tgt_idx, half_q, word_q[HWRD_W-1:0], 2'b00};
        mem_wdata = dmem[{tgt_e, half_q, word_q[HWRD_W-1:0]}];
      end
      S_FILL: mem_addr = {a_tag, a_idx, word_q, 2'b00};
      S_THRU: begin
        mem_addr  = {addr_q[31:2], 2'b00};
        mem_wdata = lane;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_hit)   dmem[{hit_e, a_wrd}]  <= merged;
    if (fill_we)  dmem[{tgt_e, word_q}] <= mem_rdata;
    if (fill_end) tagm[tgt_e]           <= a_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= '0;
      size_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      way_q   <= '0;
      tgt_way <= '0;
      tgt_idx <= '0;
      half_q  <= 1'b0;
      word_q  <= '0;
      cost_q  <= '0;
      rdata_q <= '0;
      hit_q   <= 1'b0;
      abs_q   <= 1'b0;
      vld     <= '0;
      dlo     <= '0;
      dhi     <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op_q    <= req_op;
          size_q  <= req_size;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          way_q   <= req_way;
          cost_q  <= '0;
          rdata_q <= '0;
          hit_q   <= 1'b0;
          abs_q   <= 1'b0;
          half_q  <= 1'b0;
          word_q  <= '0;
          st      <= S_LOOK;
        end
        S_LOOK: begin
          case (op_q)
            OP_RD: begin
              hit_q <= hit;
              if (hit) begin
                rdata_q <= hword;
                cost_q  <= COST_W'(1);
                st      <= S_RESP;
              end else begin
                tgt_idx <= a_idx;
                tgt_way <= way_q;
                st      <= S_WB;
              end
            end
            OP_WR: begin
              hit_q <= hit;
              if (hit) begin
                if (a_half) dhi[hit_e] <= 1'b1;
                else        dlo[hit_e] <= 1'b1;
                cost_q <= COST_W'(1);
                abs_q  <= 1'b1;
                st     <= S_RESP;
              end else st <= S_THRU;
            end
            OP_CSW: begin
              tgt_idx <= a_idx;
              tgt_way <= way_q;
              st      <= S_WB;
            end
            OP_CAD: begin
              hit_q <= hit;
              tgt_idx <= a_idx;
              tgt_way <= hway;
              st      <= hit ? S_WB : S_RESP;
            end
            OP_CALL: begin
              tgt_idx <= '0;
              tgt_way <= '0;
              st      <= S_WB;
            end
            default: st <= S_RESP;
          endcase
        end
        S_WB: begin
          if (half_end) begin
            if (wb_need) cost_q <= cost_q + HALF_COST;
            word_q <= '0;
            if (!half_q) half_q <= 1'b1;
            else begin
              half_q     <= 1'b0;
              dlo[tgt_e] <= 1'b0;
              dhi[tgt_e] <= 1'b0;
              if (op_q == OP_RD) st <= S_FILL;
              else if (op_q == OP_CALL && !(&tgt_e)) {tgt_way, tgt_idx} <= E_W'(tgt_e + 1'b1);
              else st <= S_RESP;
            end
          end else if (mem_ready) word_q <= word_q + 1'b1;
        end
        S_FILL: if (mem_ready) begin
          if (word_q == a_wrd) rdata_q <= mem_rdata;
          word_q <= word_q + 1'b1;
          if (&word_q) begin
            vld[tgt_e] <= 1'b1;
            cost_q     <= cost_q + LINE_COST;
            st         <= S_RESP;
          end
        end
        S_THRU: if (mem_ready) begin
          cost_q <= THRU_COST;
          st     <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R12
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  // R12
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  // R3
  hit_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_absorbed |-> rsp_cost == COST_W'(1) && rsp_hit);

  // R4
  dirty_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ($past(a_half) ? dhi[$past(hit_e)] : dlo[$past(hit_e)]));
endmodule

// File: tb/wb_dcache_bench.sv
module wb_dcache_bench;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_ready;
  logic [2:0]  req_op = 0;
  logic [1:0]  req_size = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [1:0]  req_way = 0;
  logic        rsp_valid, rsp_hit, rsp_absorbed;
  logic [31:0] rsp_rdata;
  logic [15:0] rsp_cost;
  logic        mem_valid, mem_we;
  logic        mem_ready = 0;
  logic [3:0]  mem_be;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 0;

  wb_dcache u_wb_dcache (.*);

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] backing [256];
  logic [31:0] golden  [256];
  bit          mv [16], mdlo [16], mdhi [16];
  logic [24:0] mtag [16];
  int n_wr, n_rd, bus_err, first_w, last_w;
  logic [2:0] cur_op;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] wd,
                                        input logic [1:0] sz, input logic [1:0] lo);
    logic [31:0] r = old;
    if (sz == 0) r[lo*8 +: 8] = wd[7:0];
    else if (sz == 1) r[lo[1]*16 +: 16] = wd[15:0];
    else r = wd;
    return r;
  endfunction

  always @(negedge clk) begin
    cycles++;
    mem_ready = ($urandom % 4) != 0;
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_addr >= 32'd1024) bus_err++;
      else if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) backing[mem_addr[9:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
        if (backing[mem_addr[9:2]] != golden[mem_addr[9:2]]) bus_err++;
        if (cur_op != 3'd1 && mem_addr[3:0] != 0 && mem_addr != last_w + 4) bus_err++;
        if (first_w < 0) first_w = mem_addr;
        last_w = mem_addr;
        n_wr++;
      end else begin
        mem_rdata = backing[mem_addr[9:2]];
        if (mem_addr[4:2] != 3'(n_rd)) bus_err++;
        n_rd++;
      end
    end
  end

  task automatic clean_model(input int e, inout int nw, inout int cost);
    if (mv[e]) begin
      if (mdlo[e]) begin nw += 4; cost += 22; end
      if (mdhi[e]) begin nw += 4; cost += 22; end
      mdlo[e] = 0; mdhi[e] = 0;
    end
  endtask

  task automatic req(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] a,
                     input logic [31:0] wd, input logic [1:0] way, input string tag);
    int idx = a[6:5], hw = -1, nw = 0, nr = 0, cost = 0, e;
    bit absd = 0, hitx;
    for (int w = 0; w < 4; w++) if (mv[w*4+idx] && mtag[w*4+idx] == a[31:7]) hw = w;
    hitx = (hw >= 0) && (op <= 3'd1 || op == 3'd3);
    case (op)
      3'd0: if (hw >= 0) cost = 1;
            else begin
              e = way*4 + idx;
              clean_model(e, nw, cost);
              nr = 8; cost += 38; mv[e] = 1; mtag[e] = a[31:7];
            end
      3'd1: begin
              golden[a[9:2]] = merge(golden[a[9:2]], wd, sz, a[1:0]);
              if (hw >= 0) begin
                cost = 1; absd = 1;
                if (a[4]) mdhi[hw*4+idx] = 1; else mdlo[hw*4+idx] = 1;
              end else begin nw = 1; cost = 10; end
            end
      3'd2: clean_model(way*4 + idx, nw, cost);
      3'd3: if (hw >= 0) clean_model(hw*4 + idx, nw, cost);
      default: for (int k = 0; k < 16; k++) clean_model(k, nw, cost);
    endcase
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    n_wr = 0; n_rd = 0; bus_err = 0; first_w = -1; last_w = 0; cur_op = op;
    req_valid = 1; req_op = op; req_size = sz; req_addr = a; req_wdata = wd; req_way = way;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_cost == 16'(cost), {tag, " cost R7"}, rsp_cost, cost);
    chk(n_wr == nw && n_rd == nr, {tag, " bus transfers R6"}, n_wr*256 + n_rd, nw*256 + nr);
    chk(bus_err == 0, {tag, " bus order/data R11"}, bus_err, 0);
    chk(rsp_hit == hitx, {tag, " hit R2"}, rsp_hit, hitx);
    if (op == 3'd0) chk(rsp_rdata == golden[a[9:2]], {tag, " rdata R2"}, rsp_rdata, golden[a[9:2]]);
    if (op == 3'd1) chk(rsp_absorbed == absd, {tag, " absorbed R5"}, rsp_absorbed, absd);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin
      backing[i] = $urandom; golden[i] = backing[i];
    end
    for (int i = 0; i < 16; i++) begin mv[i] = 0; mdlo[i] = 0; mdhi[i] = 0; mtag[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_valid, "reset state R1", {req_ready, rsp_valid, mem_valid}, 3'b100);
    req(0, 2, 32'h040, 0, 1, "first read miss R1");
    req(0, 2, 32'h044, 0, 1, "read hit R2");
    req(1, 0, 32'h053, 32'hA5, 0, "byte write hit upper R3");
    req(1, 1, 32'h046, 32'h1234, 0, "half write hit lower R3");
    req(2, 0, 32'h040, 0, 1, "clean set/way R4 R8");
    chk(first_w == 32'h040, "lower half first R6", first_w, 32'h040);
    req(2, 0, 32'h040, 0, 1, "second clean R8");
    req(0, 2, 32'h050, 0, 2, "read after clean hits R8");
    req(2, 0, 32'h040, 0, 3, "clean invalid way R8");
    req(1, 1, 32'h2A2, 32'hBEEF, 0, "write miss R5");
    req(0, 2, 32'h2A0, 0, 0, "no allocate R5");
    req(1, 2, 32'h2B4, 32'hCAFEF00D, 0, "upper write hit R4");
    req(0, 2, 32'h3A0, 0, 0, "dirty victim miss R6 R7");
    chk(first_w == 32'h2B0, "upper half only R4", first_w, 32'h2B0);
    req(3, 0, 32'h100, 0, 0, "clean addr miss R9");
    req(1, 0, 32'h3A1, 32'h77, 0, "dirty lower R4");
    req(3, 0, 32'h3A0, 0, 0, "clean addr hit R9");
    for (int i = 0; i < 500; i++) begin
      int r = $urandom % 20;
      logic [2:0] op = r < 8 ? 3'd0 : r < 15 ? 3'd1 : r < 17 ? 3'd2 : r < 19 ? 3'd3 : 3'd4;
      req(op, 2'($urandom % 3), $urandom % 1024, $urandom, 2'($urandom), "random");
    end
    req(4, 0, 0, 0, 0, "clean all R10");
    for (int i = 0; i < 256; i++)
      if (backing[i] != golden[i]) chk(0, "memory after clean all R10", backing[i], golden[i]);
    chk(1, "memory compare done R10", 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++; fails++;
    $display("FAIL watchdog R12: actual %0d expected %0d", cycles, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule